// File: doc/BRIEF.md
# Write Burst Sequencer

The sequencer sits between a memory controller's command scheduler and the double-data-rate write datapath. It accepts one write command per pulse and, for each one, produces the cycle-accurate schedule that the physical layer needs. This schedule covers when the data strobe is driven, which clocks carry preamble or postamble, which clocks carry write data (two beats per clock) and which beat pair is due. It also flags the clock from which write recovery and write-to-read timing start counting.

Write latency is the sum of the programmed additive and write CAS latencies. The burst length comes from a 2-bit mode field. In per-command mode, a select bit sent with the command picks either a full 8-beat burst or a chopped 4-beat burst, and the chopped burst still takes up the full 8-beat command slot. In fixed-chop mode, every burst is 4 beats long and uses a shorter slot. The block captures all configuration when it accepts a command, and it tracks several overlapping bursts in a small array of countdown slots.

Top module: `write_burst_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no command issued, every output is 0.
- R2: For a command sampled in clock c, data clocks start at clock c+WL, where WL = cfg_al_i + cfg_cwl_i. Each data clock carries two beats, and beat_idx_o gives the even beat index 0, 2, 4, 6 of successive data clocks.
- R3: With cfg_mode_i = 2'b01, cmd_bl8_i = 1 gives 4 data clocks and cmd_bl8_i = 0 gives 2 data clocks.
- R4: With cfg_mode_i = 2'b10 every burst has 2 data clocks. With 2'b00 or 2'b11 every burst has 4 data clocks. In these three modes cmd_bl8_i has no effect.
- R5: dqs_pre_o is high in the P clocks just before the first data clock, where P = 1 when cfg_pre2_i = 0 and P = 2 otherwise. It is not raised in a clock that carries data.
- R6: dqs_post_o is high in the clock after a burst's last data clock, unless that clock carries data or preamble of another burst.
- R7: dqs_en_o is high in exactly the clocks with preamble, data or postamble. As a result, the strobe stays continuous across back-to-back bursts.
- R8: wr_end_o pulses for one clock at c+WL+4 in modes 2'b01, 2'b00 and 2'b11 (including chopped bursts in mode 2'b01), and at c+WL+2 in mode 2'b10.
- R9: beat_bg_o carries the bank-group tag of the command that owns the current data clock.
- R10: Configuration inputs are captured with the command. Changing them afterwards does not alter a burst that is already pending.
- R11: Up to DEPTH bursts can be pending at once, with their windows overlapping in time.
- R12: Asserting rst_ni low discards all pending bursts, so none of their data, strobe or end pulses appear afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Write command pulse |
| cmd_bg_i | input | BG_W | Bank-group tag of the command |
| cmd_bl8_i | input | 1 | Per-command length select: 1 = 8 beats, 0 = chopped 4 |
| cfg_al_i | input | LAT_W | Additive latency in clocks |
| cfg_cwl_i | input | LAT_W | Write CAS latency in clocks |
| cfg_mode_i | input | 2 | Burst mode field |
| cfg_pre2_i | input | 1 | 1 = two-clock preamble, 0 = one-clock preamble |
| dqs_en_o | output | 1 | Strobe driven this clock |
| dqs_pre_o | output | 1 | Preamble clock |
| dqs_post_o | output | 1 | Postamble clock |
| beat_valid_o | output | 1 | This clock carries two write beats |
| beat_idx_o | output | 3 | Index of the first beat in this clock |
| beat_bg_o | output | BG_W | Bank group owning the data clock |
| wr_end_o | output | 1 | First clock after the burst slot ends |

## Verification
The assertions assume three things about the controller. Commands are spaced by at least the burst slot, which is 4 clocks, or 2 clocks in fixed-chop mode. WL is at least P+1. No more than DEPTH bursts are ever pending at once. Given these, data windows from different slots never overlap, and every first data clock is preceded by preamble within its own slot. The stimulus uses command spacings of exactly the slot length or more, latencies of 9 or above, and a deep pipeline test sized to fill seven of the eight slots.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic [1:0] {
    BM_FIX8  = 2'b00,
    BM_OTF   = 2'b01,
    BM_CHOP  = 2'b10,
    BM_FIX8B = 2'b11
  } burst_mode_e;

  typedef struct packed {
    logic [2:0] data_clks;
    logic [2:0] slot_clks;
  } burst_len_t;

  function automatic burst_len_t decode_len(input logic [1:0] mode, input logic bl8);
    burst_len_t r;
    unique case (burst_mode_e'(mode))
      BM_OTF:  begin r.data_clks = bl8 ? 3'd4 : 3'd2; r.slot_clks = 3'd4; end
      BM_CHOP: begin r.data_clks = 3'd2;              r.slot_clks = 3'd2; end
      default: begin r.data_clks = 3'd4;              r.slot_clks = 3'd4; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wbs_alloc.sv
module wbs_alloc #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] busy_i,
  input  logic             req_i,
  output logic [DEPTH-1:0] grant_o,
  output logic             full_o
);

  logic found;

  // lowest free slot wins
  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!busy_i[i] && !found) begin
        grant_o[i] = req_i;
        found      = 1'b1;
      end
    end
    full_o = !found;
  end

endmodule

// File: rtl/wbs_slot.sv
module wbs_slot #(
  parameter int CNT_W = 7,
  parameter int BG_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] wl_i,
  input  logic             pre2_i,
  input  logic [2:0]       data_clks_i,
  input  logic [2:0]       slot_clks_i,
  input  logic [BG_W-1:0]  bg_i,
  output logic             busy_o,
  output logic             pre_o,
  output logic             data_o,
  output logic [2:0]       idx_o,
  output logic             post_cand_o,
  output logic             end_o,
  output logic [BG_W-1:0]  bg_o
);

  logic             vld_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wl_q;
  logic             pre2_q;
  logic [2:0]       dclk_q;
  logic [2:0]       sclk_q;
  logic [BG_W-1:0]  bg_q;

  logic [CNT_W:0] cnt_x, wl_x, data_end, slot_end, pre_start;
  logic [1:0]     beat_off;

  always_comb begin
    cnt_x     = {1'b0, cnt_q};
    wl_x      = {1'b0, wl_q};
    data_end  = wl_x + (CNT_W+1)'(dclk_q);
    slot_end  = wl_x + (CNT_W+1)'(sclk_q);
    pre_start = wl_x - (pre2_q ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
    beat_off  = cnt_q[1:0] - wl_q[1:0];
  end

  // cnt counts clocks since the command clock; loaded as 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      wl_q   <= '0;
      pre2_q <= 1'b0;
      dclk_q <= '0;
      sclk_q <= '0;
      bg_q   <= '0;
    end else if (load_i) begin
      vld_q  <= 1'b1;
      cnt_q  <= CNT_W'(1);
      wl_q   <= wl_i;
      pre2_q <= pre2_i;
      dclk_q <= data_clks_i;
      sclk_q <= slot_clks_i;
      bg_q   <= bg_i;
    end else if (vld_q) begin
      if (cnt_x == slot_end) vld_q <= 1'b0;
      else                   cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign busy_o      = vld_q;
  assign pre_o       = vld_q && (cnt_x >= pre_start) && (cnt_x < wl_x);
  assign data_o      = vld_q && (cnt_x >= wl_x) && (cnt_x < data_end);
  assign post_cand_o = vld_q && (cnt_x == data_end);
  assign end_o       = vld_q && (cnt_x == slot_end);
  assign idx_o       = {beat_off, 1'b0};
  assign bg_o        = bg_q;

  p_pre_lead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o && !$past(data_o)) |-> $past(pre_o));

  p_idx_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o && $past(data_o)) |-> (idx_o == $past(idx_o) + 3'd2));

  p_post_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_cand_o |-> $past(data_o));

  p_end_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !busy_o);

endmodule

// File: rtl/wbs_merge.sv
module wbs_merge #(
  parameter int DEPTH = 8,
  parameter int BG_W  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DEPTH-1:0]          pre_v_i,
  input  logic [DEPTH-1:0]          data_v_i,
  input  logic [DEPTH-1:0]          cand_v_i,
  input  logic [DEPTH-1:0]          end_v_i,
  input  logic [DEPTH-1:0][2:0]     idx_i,
  input  logic [DEPTH-1:0][BG_W-1:0] bg_i,
  output logic                      dqs_en_o,
  output logic                      dqs_pre_o,
  output logic                      dqs_post_o,
  output logic                      beat_valid_o,
  output logic [2:0]                beat_idx_o,
  output logic [BG_W-1:0]           beat_bg_o,
  output logic                      wr_end_o
);

  logic any_pre, any_data, any_cand;

  always_comb begin
    beat_idx_o = '0;
    beat_bg_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (data_v_i[i]) begin
        beat_idx_o = beat_idx_o | idx_i[i];
        beat_bg_o  = beat_bg_o | bg_i[i];
      end
    end
    any_pre  = |pre_v_i;
    any_data = |data_v_i;
    any_cand = |cand_v_i;
  end

  // a neighbour's preamble or data overrides the postamble
  assign beat_valid_o = any_data;
  assign dqs_pre_o    = any_pre && !any_data;
  assign dqs_post_o   = any_cand && !any_pre && !any_data;
  assign dqs_en_o     = any_pre || any_data || any_cand;
  assign wr_end_o     = |end_v_i;

  p_data_owner_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(data_v_i));

  p_end_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(end_v_i));

endmodule

// File: rtl/write_burst_seq.sv
module write_burst_seq #(
  parameter int DEPTH = 8,
  parameter int BG_W  = 2,
  parameter int LAT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [BG_W-1:0]  cmd_bg_i,
  input  logic             cmd_bl8_i,
  input  logic [LAT_W-1:0] cfg_al_i,
  input  logic [LAT_W-1:0] cfg_cwl_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             cfg_pre2_i,
  output logic             dqs_en_o,
  output logic             dqs_pre_o,
  output logic             dqs_post_o,
  output logic             beat_valid_o,
  output logic [2:0]       beat_idx_o,
  output logic [BG_W-1:0]  beat_bg_o,
  output logic             wr_end_o
);
  import wbs_pkg::*;

  localparam int CNT_W = LAT_W + 2;

  logic [CNT_W-1:0]          wl;
  burst_len_t                blen;
  logic [DEPTH-1:0]          busy, grant;
  logic                      full;
  logic [DEPTH-1:0]          pre_v, data_v, cand_v, end_v;
  logic [DEPTH-1:0][2:0]     idx_v;
  logic [DEPTH-1:0][BG_W-1:0] bg_v;

  assign wl   = CNT_W'(cfg_al_i) + CNT_W'(cfg_cwl_i);
  assign blen = decode_len(cfg_mode_i, cmd_bl8_i);

  wbs_alloc #(.DEPTH(DEPTH)) u_alloc (
    .busy_i  (busy),
    .req_i   (cmd_valid_i),
    .grant_o (grant),
    .full_o  (full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    wbs_slot #(.CNT_W(CNT_W), .BG_W(BG_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (grant[g]),
      .wl_i        (wl),
      .pre2_i      (cfg_pre2_i),
      .data_clks_i (blen.data_clks),
      .slot_clks_i (blen.slot_clks),
      .bg_i        (cmd_bg_i),
      .busy_o      (busy[g]),
      .pre_o       (pre_v[g]),
      .data_o      (data_v[g]),
      .idx_o       (idx_v[g]),
      .post_cand_o (cand_v[g]),
      .end_o       (end_v[g]),
      .bg_o        (bg_v[g])
    );
  end

  wbs_merge #(.DEPTH(DEPTH), .BG_W(BG_W)) u_merge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pre_v_i      (pre_v),
    .data_v_i     (data_v),
    .cand_v_i     (cand_v),
    .end_v_i      (end_v),
    .idx_i        (idx_v),
    .bg_i         (bg_v),
    .dqs_en_o     (dqs_en_o),
    .dqs_pre_o    (dqs_pre_o),
    .dqs_post_o   (dqs_post_o),
    .beat_valid_o (beat_valid_o),
    .beat_idx_o   (beat_idx_o),
    .beat_bg_o    (beat_bg_o),
    .wr_end_o     (wr_end_o)
  );

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> !full);

  p_wl_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> (wl >= (cfg_pre2_i ? CNT_W'(3) : CNT_W'(2))));

  p_quiet_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy == '0) |-> !dqs_en_o);

endmodule

// File: tb/sim_write_burst_seq.sv
module sim_write_burst_seq;

  localparam int MAXC = 2048;
  localparam int WD   = 20000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_bg = '0;
  logic       cmd_bl8 = 1'b0;
  logic [4:0] cfg_al = '0;
  logic [4:0] cfg_cwl = 5'd9;
  logic [1:0] cfg_mode = 2'b01;
  logic       cfg_pre2 = 1'b0;
  logic       dqs_en, dqs_pre, dqs_post, beat_valid, wr_end;
  logic [2:0] beat_idx;
  logic [1:0] beat_bg;

  write_burst_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_bg_i(cmd_bg),
    .cmd_bl8_i(cmd_bl8), .cfg_al_i(cfg_al), .cfg_cwl_i(cfg_cwl),
    .cfg_mode_i(cfg_mode), .cfg_pre2_i(cfg_pre2), .dqs_en_o(dqs_en),
    .dqs_pre_o(dqs_pre), .dqs_post_o(dqs_post), .beat_valid_o(beat_valid),
    .beat_idx_o(beat_idx), .beat_bg_o(beat_bg), .wr_end_o(wr_end)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int c; int idx; int bg; } beat_t;
  beat_t beat_q[$];
  int    end_q[$];
  bit    e_pre [MAXC];
  bit    e_data[MAXC];
  bit    e_cand[MAXC];
  int    n_chk = 0;
  int    n_bad = 0;
  string ctx = "base";
  bit    done = 1'b0;

  function automatic void chk(input bit ok, input string req, input string what,
                              input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s [%s] cycle %0d: actual %0d expected %0d",
               req, what, ctx, cyc, act, exp);
    end
  endfunction

  // driver: one command, expected schedule pushed to the scoreboard
  task automatic issue(input int bg, input bit bl8);
    int wl, n, slot, p, c0;
    @(negedge clk);
    c0 = cyc;
    cmd_valid = 1'b1; cmd_bg = 2'(bg); cmd_bl8 = bl8;
    wl   = int'(cfg_al) + int'(cfg_cwl);
    n    = (cfg_mode == 2'b01) ? (bl8 ? 4 : 2) : (cfg_mode == 2'b10 ? 2 : 4);
    slot = (cfg_mode == 2'b10) ? 2 : 4;
    p    = cfg_pre2 ? 2 : 1;
    for (int k = 0; k < n; k++) begin
      beat_t b;
      e_data[c0+wl+k] = 1'b1;
      b.c = c0 + wl + k; b.idx = 2 * k; b.bg = bg;
      beat_q.push_back(b);
    end
    for (int k = 1; k <= p; k++) e_pre[c0+wl-k] = 1'b1;
    e_cand[c0+wl+n] = 1'b1;
    end_q.push_back(c0 + wl + slot);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset(input int n);
    @(negedge clk);
    rst_ni = 1'b0;
    for (int c = cyc; c < MAXC; c++) begin
      e_pre[c] = 1'b0; e_data[c] = 1'b0; e_cand[c] = 1'b0;
    end
    beat_q.delete();
    end_q.delete();
    repeat (n) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // monitor: compare strobe flags per clock, pop beats and end pulses
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!done && cyc < MAXC) begin
        bit xp, xd, xc;
        xp = e_pre[cyc]; xd = e_data[cyc]; xc = e_cand[cyc];
        chk(dqs_pre == (xp && !xd), "R5", "dqs_pre_o", dqs_pre, xp && !xd);
        chk(dqs_post == (xc && !xp && !xd), "R6", "dqs_post_o", dqs_post, xc && !xp && !xd);
        chk(dqs_en == (xp || xd || xc), "R7", "dqs_en_o", dqs_en, xp || xd || xc);
        while (beat_q.size() > 0 && beat_q[0].c < cyc) begin
          chk(1'b0, "R2", "missing data clock at", 0, beat_q[0].c);
          void'(beat_q.pop_front());
        end
        if (beat_valid) begin
          if (beat_q.size() == 0 || beat_q[0].c != cyc) begin
            chk(1'b0, "R3", "unexpected data clock", 1, 0);
          end else begin
            chk(beat_idx == 3'(beat_q[0].idx), "R2", "beat_idx_o", beat_idx, beat_q[0].idx);
            chk(beat_bg == 2'(beat_q[0].bg), "R9", "beat_bg_o", beat_bg, beat_q[0].bg);
            void'(beat_q.pop_front());
          end
        end
        while (end_q.size() > 0 && end_q[0] < cyc) begin
          chk(1'b0, "R8", "missing wr_end_o at", 0, end_q[0]);
          void'(end_q.pop_front());
        end
        if (wr_end) begin
          if (end_q.size() == 0 || end_q[0] != cyc) chk(1'b0, "R8", "unexpected wr_end_o", 1, 0);
          else begin
            chk(1'b1, "R8", "wr_end_o", 1, 1);
            void'(end_q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R1", "watchdog expired", cyc, WD);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    ctx = "R1";
    @(negedge clk); #1;
    chk(!dqs_en && !dqs_pre && !dqs_post && !beat_valid && !wr_end, "R1",
        "outputs in reset", int'(dqs_en | beat_valid | wr_end), 0);
    idle(2);
    rst_ni = 1'b1;
    idle(3);
    chk(!dqs_en && !beat_valid && !wr_end, "R1", "outputs after reset",
        int'(dqs_en | beat_valid | wr_end), 0);

    // single 8-beat, then single chop in per-command mode
    ctx = "R3";
    cfg_mode = 2'b01; cfg_al = 0; cfg_cwl = 9; cfg_pre2 = 0;
    issue(1, 1'b1); idle(20);
    issue(2, 1'b0); idle(20);

    // back-to-back slots, mixed lengths, different bank groups
    ctx = "R7";
    issue(0, 1'b1); idle(2);
    issue(1, 1'b1); idle(2);
    issue(2, 1'b0); idle(2);
    issue(3, 1'b1); idle(25);

    // two-clock preamble overlapping previous data
    ctx = "R5";
    cfg_pre2 = 1; cfg_al = 2; cfg_cwl = 10;
    issue(3, 1'b1); idle(2);
    issue(0, 1'b0); idle(2);
    issue(1, 1'b0); idle(25);

    // fixed chop, select bit ignored, spacing 2
    ctx = "R4";
    cfg_pre2 = 0; cfg_al = 0; cfg_cwl = 9; cfg_mode = 2'b10;
    issue(0, 1'b1);
    issue(1, 1'b0);
    issue(2, 1'b1);
    issue(3, 1'b1); idle(25);
    cfg_mode = 2'b00;
    issue(1, 1'b0); idle(2);
    issue(2, 1'b1); idle(20);
    cfg_mode = 2'b11;
    issue(3, 1'b0); idle(20);

    // configuration changed while a burst is pending
    ctx = "R10";
    cfg_mode = 2'b01; cfg_cwl = 9; cfg_pre2 = 0;
    issue(2, 1'b1);
    cfg_cwl = 15; cfg_mode = 2'b10; cfg_pre2 = 1;
    idle(2);
    issue(1, 1'b1); idle(30);

    // deep pipeline: seven pending bursts
    ctx = "R11";
    cfg_mode = 2'b10; cfg_al = 3; cfg_cwl = 9; cfg_pre2 = 0;
    for (int i = 0; i < 7; i++) issue(i % 4, 1'b0);
    idle(30);

    // reset while bursts are pending
    ctx = "R12";
    cfg_mode = 2'b01; cfg_al = 0; cfg_cwl = 12;
    issue(1, 1'b1); idle(2);
    issue(2, 1'b1); idle(2);
    apply_reset(3);
    idle(30);
    chk(!dqs_en && !beat_valid && !wr_end, "R12", "quiet after reset",
        int'(dqs_en | beat_valid | wr_end), 0);

    idle(5);
    chk(beat_q.size() == 0, "R2", "beats left pending", beat_q.size(), 0);
    chk(end_q.size() == 0, "R8", "end pulses left pending", end_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule